// File: doc/BRIEF.md
# Dual Prescaled Reload Timer

This block holds two 16-bit down-counters that share one fixed time base. The time base gives one tick every twenty system clocks. On each tick an enabled counter steps down by one. A counter that is already at zero loads the value held in its own reload register instead, and it sets a sticky zero flag for that channel. Each flag can raise an interrupt line of its own. The second channel (index 1) can also toggle a waveform pin at every reload, so the pin makes a square wave whose half-period is set by the reload value.

Software uses a small register bus. A write strobe or a read strobe comes with an address and write data. The read data is a function of the address alone, with no clock delay, so a peek with the read strobe low has no side effects. To clear a channel's zero flag, software first reads the status word and then reads that channel's counter.

Top module: `dual_reload_timer`

## Requirements
- R1: After reset every register reads zero: both counters, both reload values, control and status. Both irq bits and wave_out are low.
- R2: The shared tick fires on every twentieth rising clock edge after reset is released. An enabled counter changes only at a tick, so two successive steps of a running counter lie exactly 20 clocks apart.
- R3: At a tick, an enabled counter that is not zero drops by exactly one. A disabled counter holds its value.
- R4: At a tick, an enabled counter that is at zero takes its reload value and sets its sticky zero flag. The flags are status bit 0 for channel 0 and status bit 1 for channel 1.
- R5: A counter write takes effect only while that channel is disabled and is ignored while it runs. A reload write is accepted at any time and is used at the next reload.
- R6: A status read (read strobe at address 5) made while a flag is set arms that flag. A later read strobe at that channel's counter address clears the flag. A counter read that was not armed leaves the flag set. If a reload sets the flag in the same cycle as the clearing read, the flag stays set.
- R7: irq[i] is high exactly when channel i's zero flag is set and its interrupt-enable bit is set. The interrupt-enable bits are control bit 2 for channel 0 and control bit 3 for channel 1.
- R8: With the wave-enable bit (control bit 4) set, wave_out toggles at each reload of channel 1. With that bit clear, wave_out keeps its level. Reloads of channel 0 never move wave_out. Status bit 2 reads the wave_out level.
- R9: The register map is: 0 counter 0, 1 reload 0, 2 counter 1, 3 reload 1, 4 control, 5 status. Control bits 0 and 1 are the run enables of channels 0 and 1. Control reads back as written in bits 4:0. Addresses 6 and 7 read zero. Read data follows the address in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; has side effects only on flag clearing |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, with no clock delay |
| irq | output | 2 | Per-channel interrupt requests |
| wave_out | output | 1 | Channel 1 toggle output |

## Verification
Read data is due in the same cycle as its address. The bench drives the bus just after a falling edge and samples bus_rdata one nanosecond later. Writes, flag changes and counter steps land on the next rising edge, and irq and wave_out settle with no extra register after that edge, so both are compared at every falling edge. A behavioural model advances on the same rising edges and counts the prescale phase itself. The expected tick, the first one on the twentieth edge after reset release, therefore falls in the same cycle that the design updates.

// File: rtl/drt_pkg.sv
package drt_pkg;
   localparam int unsigned ADDR_W = 3;
   localparam int unsigned NCH    = 2;

   typedef enum logic [ADDR_W-1:0] {
      RA_CNT0 = 3'd0,
      RA_RLD0 = 3'd1,
      RA_CNT1 = 3'd2,
      RA_RLD1 = 3'd3,
      RA_CTRL = 3'd4,
      RA_STAT = 3'd5
   } reg_addr_e;

   // control bit positions
   localparam int unsigned CB_RUN0 = 0;
   localparam int unsigned CB_IE0  = 2;
   localparam int unsigned CB_WAVE = 4;
   localparam int unsigned CTRL_W  = 5;

   // status bit positions
   localparam int unsigned SB_FLAG0 = 0;
   localparam int unsigned SB_WAVE  = 2;

   function automatic logic [ADDR_W-1:0] cnt_addr(int unsigned ch);
      return ADDR_W'(2 * ch);
   endfunction

   function automatic logic [ADDR_W-1:0] rld_addr(int unsigned ch);
      return ADDR_W'(2 * ch + 1);
   endfunction
endpackage

// File: rtl/drt_prescaler.sv
module drt_prescaler #(
   parameter int unsigned DIV = 20
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [PW-1:0] LAST = PW'(DIV - 1);

   if (DIV < 2) begin : g_bad_div
      $error("drt_prescaler: DIV must be at least 2");
   end

   logic [PW-1:0] phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         phase_q <= '0;
      else if (phase_q == LAST)
         phase_q <= '0;
      else
         phase_q <= phase_q + 1'b1;
   end

   assign tick = (phase_q == LAST);
endmodule

// File: rtl/drt_channel.sv
module drt_channel #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             run,
   input  logic             cnt_we,
   input  logic             rld_we,
   input  logic [CNT_W-1:0] wdata,
   input  logic             stat_rd,
   input  logic             cnt_rd,
   output logic [CNT_W-1:0] count,
   output logic [CNT_W-1:0] reload,
   output logic             flag
);
   logic [CNT_W-1:0] cnt_q, rld_q;
   logic             flag_q, armed_q;
   logic             at_zero, reload_hit, clear_hit;

   assign at_zero    = (cnt_q == '0);
   assign reload_hit = tick & run & at_zero;
   assign clear_hit  = armed_q & cnt_rd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (cnt_we && !run)
         cnt_q <= wdata;
      else if (tick && run)
         cnt_q <= at_zero ? rld_q : cnt_q - 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rld_q <= '0;
      else if (rld_we)
         rld_q <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q  <= 1'b0;
         armed_q <= 1'b0;
      end else begin
         if (reload_hit)
            flag_q <= 1'b1;
         else if (clear_hit)
            flag_q <= 1'b0;
         if (clear_hit)
            armed_q <= 1'b0;
         else if (stat_rd && flag_q)
            armed_q <= 1'b1;
      end
   end

   assign count  = cnt_q;
   assign reload = rld_q;
   assign flag   = flag_q;
endmodule

// File: rtl/drt_readmux.sv
module drt_readmux
   import drt_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic [ADDR_W-1:0]         addr,
   input  logic [NCH-1:0][CNT_W-1:0] cnt_v,
   input  logic [NCH-1:0][CNT_W-1:0] rld_v,
   input  logic [CTRL_W-1:0]         ctrl,
   input  logic [NCH-1:0]            flag,
   input  logic                      wave,
   output logic [CNT_W-1:0]          rdata
);
   always_comb begin
      rdata = '0;
      case (reg_addr_e'(addr))
         RA_CNT0: rdata = cnt_v[0];
         RA_RLD0: rdata = rld_v[0];
         RA_CNT1: rdata = cnt_v[1];
         RA_RLD1: rdata = rld_v[1];
         RA_CTRL: rdata[CTRL_W-1:0] = ctrl;
         RA_STAT: begin
            rdata[SB_FLAG0 +: NCH] = flag;
            rdata[SB_WAVE]         = wave;
         end
         default: rdata = '0;
      endcase
   end
endmodule

// File: rtl/dual_reload_timer.sv
module dual_reload_timer
   import drt_pkg::*;
#(
   parameter int unsigned CNT_W    = 16,
   parameter int unsigned PRESCALE = 20,
   parameter int unsigned WAVE_CH  = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_wr,
   input  logic             bus_rd,
   input  logic [2:0]       bus_addr,
   input  logic [CNT_W-1:0] bus_wdata,
   output logic [CNT_W-1:0] bus_rdata,
   output logic [1:0]       irq,
   output logic             wave_out
);
   if (CNT_W < CTRL_W) begin : g_bad_width
      $error("dual_reload_timer: CNT_W too narrow for the control word");
   end
   if (WAVE_CH >= NCH) begin : g_bad_wave
      $error("dual_reload_timer: WAVE_CH out of range");
   end

   logic                      tick;
   logic [CTRL_W-1:0]         ctrl_q;
   logic [NCH-1:0]            run_v, flag_v;
   logic [NCH-1:0][CNT_W-1:0] cnt_v, rld_v;
   logic                      stat_rd;
   logic                      wave_q;

   drt_prescaler #(.DIV(PRESCALE)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctrl_q <= '0;
      else if (bus_wr && bus_addr == RA_CTRL)
         ctrl_q <= bus_wdata[CTRL_W-1:0];
   end

   assign stat_rd = bus_rd && (bus_addr == RA_STAT);

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      assign run_v[i] = ctrl_q[CB_RUN0 + i];

      drt_channel #(.CNT_W(CNT_W)) u_ch (
         .clk     (clk),
         .rst_n   (rst_n),
         .tick    (tick),
         .run     (run_v[i]),
         .cnt_we  (bus_wr && bus_addr == cnt_addr(i)),
         .rld_we  (bus_wr && bus_addr == rld_addr(i)),
         .wdata   (bus_wdata),
         .stat_rd (stat_rd),
         .cnt_rd  (bus_rd && bus_addr == cnt_addr(i)),
         .count   (cnt_v[i]),
         .reload  (rld_v[i]),
         .flag    (flag_v[i])
      );

      assign irq[i] = flag_v[i] & ctrl_q[CB_IE0 + i];

      if (i == WAVE_CH) begin : g_wave
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               wave_q <= 1'b0;
            else if (tick && run_v[i] && cnt_v[i] == '0 && ctrl_q[CB_WAVE])
               wave_q <= ~wave_q;
         end
      end
   end

   assign wave_out = wave_q;

   drt_readmux #(.CNT_W(CNT_W)) u_rmux (
      .addr  (bus_addr),
      .cnt_v (cnt_v),
      .rld_v (rld_v),
      .ctrl  (ctrl_q),
      .flag  (flag_v),
      .wave  (wave_q),
      .rdata (bus_rdata)
   );
endmodule

// File: rtl/drt_checker.sv
module drt_checker
   import drt_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      tick,
   input logic                      bus_wr,
   input logic [2:0]                bus_addr,
   input logic [NCH-1:0]            run,
   input logic [NCH-1:0][CNT_W-1:0] cnt_v,
   input logic [NCH-1:0][CNT_W-1:0] rld_v,
   input logic [NCH-1:0]            flag,
   input logic                      wave_out
);
   assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);

   assert_wave_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(wave_out) |-> $past(tick));

   for (genvar i = 0; i < NCH; i++) begin : g_chk
      assert_step_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (tick && run[i] && cnt_v[i] != '0) |=> cnt_v[i] == $past(cnt_v[i]) - 1'b1);

      assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (tick && run[i] && cnt_v[i] == '0) |=> (cnt_v[i] == $past(rld_v[i]) && flag[i]));

      assert_flag_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(flag[i]) |-> $past(tick && run[i]));

      assert_locked_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (!tick && run[i] && bus_wr && bus_addr == cnt_addr(i)) |=> $stable(cnt_v[i]));

      assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (!tick && !(bus_wr && bus_addr == cnt_addr(i))) |=> $stable(cnt_v[i]));
   end
endmodule

bind dual_reload_timer drt_checker #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick     (tick),
   .bus_wr   (bus_wr),
   .bus_addr (bus_addr),
   .run      (run_v),
   .cnt_v    (cnt_v),
   .rld_v    (rld_v),
   .flag     (flag_v),
   .wave_out (wave_out)
);

// File: tb/dual_reload_timer_tb.sv
module dual_reload_timer_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [1:0]  irq;
   logic        wave_out;

   int n_cmp = 0, n_bad = 0, cyc = 0;

   // behavioural reference state
   int        m_cnt [2] = '{0, 0};
   int        m_rld [2] = '{0, 0};
   bit        m_flag[2] = '{0, 0};
   bit        m_arm [2] = '{0, 0};
   bit [4:0]  m_ctrl = '0;
   bit        m_wave = 1'b0;
   int        m_ph = 0;

   dual_reload_timer u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq(irq), .wave_out(wave_out));

   always #10 clk = ~clk;

   task automatic check(string tag, int got, int exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got 0x%0h expected 0x%0h at cycle %0d", tag, got, exp, cyc);
      end
   endtask

   function automatic int model_read(int a);
      case (a)
         0: return m_cnt[0];
         1: return m_rld[0];
         2: return m_cnt[1];
         3: return m_rld[1];
         4: return int'(m_ctrl);
         5: return int'(m_flag[0]) | (int'(m_flag[1]) << 1) | (int'(m_wave) << 2);
         default: return 0;
      endcase
   endfunction

   function automatic string addr_tag(int a);
      case (a)
         0, 2: return "R3";
         1, 3: return "R5";
         5:    return "R6";
         default: return "R9";
      endcase
   endfunction

   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         m_cnt = '{0, 0}; m_rld = '{0, 0}; m_flag = '{0, 0}; m_arm = '{0, 0};
         m_ctrl = '0; m_wave = 1'b0; m_ph = 0;
      end else begin
         bit tk;
         tk = (m_ph == 19);
         m_ph = tk ? 0 : m_ph + 1;
         for (int ch = 0; ch < 2; ch++) begin
            bit run, zero, clr, srd;
            run  = m_ctrl[ch];
            zero = tk && run && (m_cnt[ch] == 0);
            clr  = m_arm[ch] && bus_rd && (bus_addr == 3'(2*ch));
            srd  = bus_rd && (bus_addr == 3'd5);
            if (bus_wr && bus_addr == 3'(2*ch) && !run) m_cnt[ch] = int'(bus_wdata);
            else if (tk && run) m_cnt[ch] = zero ? m_rld[ch] : m_cnt[ch] - 1;
            if (bus_wr && bus_addr == 3'(2*ch+1)) m_rld[ch] = int'(bus_wdata);
            if (clr) m_arm[ch] = 1'b0;
            else if (srd && m_flag[ch]) m_arm[ch] = 1'b1;
            if (zero) m_flag[ch] = 1'b1;
            else if (clr) m_flag[ch] = 1'b0;
            if (ch == 1 && zero && m_ctrl[4]) m_wave = ~m_wave;
         end
         if (bus_wr && bus_addr == 3'd4) m_ctrl = bus_wdata[4:0];
      end
   end

   // outputs with no dependence on the bus are compared at every falling edge
   always @(negedge clk) begin
      check("R7", int'(irq[0]), int'(m_flag[0] && m_ctrl[2]));
      check("R7", int'(irq[1]), int'(m_flag[1] && m_ctrl[3]));
      check("R8", int'(wave_out), int'(m_wave));
   end

   task automatic step(bit w, bit r, int a, int d);
      @(negedge clk);
      bus_wr = w; bus_rd = r; bus_addr = 3'(a); bus_wdata = 16'(d);
      #1;
      check(addr_tag(a), int'(bus_rdata), model_read(a));
   endtask

   task automatic idle(int n, int a);
      for (int k = 0; k < n; k++) step(0, 0, a, 0);
   endtask

   initial begin
      int q[$];
      int prev;
      bit lvl;
      repeat (3) step(0, 0, 0, 0);
      rst_n = 1'b1;
      // R1: reset values at every address
      for (int a = 0; a < 8; a++) begin
         step(0, 0, a, 0);
         check("R1", int'(bus_rdata), 0);
      end
      check("R1", int'(irq), 0);
      check("R1", int'(wave_out), 0);

      // channel 0 running, interrupt enabled
      step(1, 0, 0, 10);
      step(1, 0, 1, 4);
      step(1, 0, 4, 5'h05);
      prev = 10;
      for (int k = 0; k < 60; k++) begin
         step(0, 0, 0, 0);
         if (int'(bus_rdata) != prev) begin q.push_back(cyc); prev = int'(bus_rdata); end
      end
      check("R2", (q.size() >= 2) ? q[1] - q[0] : -1, 20);

      idle(240, 5);
      check("R4", int'(bus_rdata[0]), 1);
      check("R7", int'(irq[0]), 1);

      // write while running is ignored
      step(1, 0, 0, 16'h1234);
      step(0, 0, 0, 0);
      check("R5", int'(bus_rdata == 16'h1234), 0);

      // unarmed counter read keeps the flag
      step(0, 1, 0, 0);
      step(0, 0, 5, 0);
      check("R6", int'(bus_rdata[0]), int'(m_flag[0]));
      // status read then counter read clears it
      step(0, 1, 5, 0);
      step(0, 1, 0, 0);
      step(0, 0, 5, 0);
      check("R6", int'(bus_rdata[0]), int'(m_flag[0]));

      // reload change while running
      step(1, 0, 1, 2);
      idle(150, 0);

      // channel 1 with wave output
      step(1, 0, 2, 1);
      step(1, 0, 3, 2);
      step(1, 0, 4, 5'h1F);
      idle(300, 2);
      step(0, 0, 4, 0);
      check("R9", int'(bus_rdata), 5'h1F);
      // wave disabled: level must hold
      step(1, 0, 4, 5'h0F);
      lvl = wave_out;
      idle(200, 5);
      check("R8", int'(wave_out), int'(lvl));
      check("R8", int'(bus_rdata[2]), int'(lvl));

      step(0, 0, 6, 0);
      check("R9", int'(bus_rdata), 0);
      step(0, 0, 7, 0);
      check("R9", int'(bus_rdata), 0);

      // everything disabled: counters hold
      step(1, 0, 4, 0);
      step(0, 0, 0, 0);
      prev = int'(bus_rdata);
      idle(60, 0);
      check("R3", int'(bus_rdata), prev);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(20 * 100000);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule